// File: doc/BRIEF.md
# Signal Monitor With Peak Hold

This block lets a host observe internal audio sample streams through a two-byte read port. Several signed 16-bit sources each arrive with their own valid strobe, and a select field picks one of them. The block keeps two results for the chosen source at all times. The first is the most recent sample. The second is the largest magnitude seen since the peak was last cleared. A mode bit decides which of the two the host reads.

A read is a pair of strobes, high byte first. The high-byte strobe returns bits 15:8 and freezes the full 16-bit value. The low-byte strobe returns bits 7:0 of that frozen value, so the two bytes always belong together. In peak mode the low-byte strobe also clears the peak, which restarts the measurement window. A sample that arrives in the same cycle as a clear starts the new window instead of being dropped. Changing the source select clears the peak in the same way.

Top module: `sig_monitor`

## Requirements
- R1: After reset, the latest-sample register, the peak register, the frozen read value and `rd_data` are all zero.
- R2: In sample mode (`peak_mode` = 0) a read returns the last sample, in two's complement, whose strobe was high while its source was selected.
- R3: A sample strobe on a source that is not selected changes neither the sample result nor the peak result.
- R4: In peak mode (`peak_mode` = 1) a read returns, as an unsigned 16-bit number, the largest absolute value of the selected source's samples since the last clear.
- R5: The magnitude of -32768 (0x8000) is taken as 32767 (0x7FFF), so the peak never has bit 15 set.
- R6: A cycle with `rd_hi` = 1 makes `rd_data` equal bits 15:8 of the value picked by the mode in the next cycle, and it freezes all 16 bits. A cycle with `rd_lo` = 1 and `rd_hi` = 0 makes `rd_data` equal bits 7:0 of the frozen value in the next cycle. When both strobes are high, only the high-byte action takes place. Otherwise `rd_data` holds its value.
- R7: The frozen value changes only on `rd_hi`, so samples that arrive between the two strobes do not alter the low byte.
- R8: A low-byte read (`rd_lo` = 1, `rd_hi` = 0) taken in peak mode clears the peak to zero. In sample mode a read leaves the peak and the sample unchanged.
- R9: If the selected source's strobe is high in the same cycle as a peak clear, the new peak is that sample's magnitude instead of zero.
- R10: A change of `src_sel` from its value in the previous cycle clears the peak, and R9 seeding applies to that cycle as well.
- R11: The mode bit, sampled on the `rd_hi` cycle, picks which result is frozen. Both results are tracked in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_bus | input | NUM_SRC*SMP_W | Packed samples; source k is in bits k*16 +: 16 |
| smp_vld | input | NUM_SRC | Per-source sample strobe; bit k qualifies source k |
| src_sel | input | SEL_W | Index of the observed source |
| peak_mode | input | 1 | 0: latest sample, 1: peak magnitude |
| rd_hi | input | 1 | High-byte read strobe; freezes the value |
| rd_lo | input | 1 | Low-byte read strobe; in peak mode clears the peak |
| rd_data | output | SMP_W/2 | Registered read byte |

## Verification
The bench targets the cycle where a clear and a sample meet. A design that clears after it updates would return zero there, and one that ignores the clear would return the old peak. It also moves a sample in between the two byte strobes. A design that reads the low byte live would then return a torn pair. Further cases cover 0x8000, which a plain negation turns into a negative peak, and a source change with and without a coincident sample. The bench also checks that sample-mode reads leave the peak untouched and that a strobe on an unselected source leaks into neither result.

// File: rtl/mon_pkg.sv
// Shared definitions for the signal monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package mon_pkg;
    typedef enum logic {
        MON_SAMPLE = 1'b0,
        MON_PEAK   = 1'b1
    } mon_mode_e;
endpackage

// File: rtl/mon_src_mux.sv
// Picks one sample lane and its strobe out of the packed input bus,
// and flags a cycle in which the select differs from last cycle.
// Assumes: src_sel < NUM_SRC; the flag is zero during reset.
module mon_src_mux #(
    parameter int NUM_SRC = 8,
    parameter int SMP_W   = 16,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC*SMP_W-1:0] smp_bus,
    input  logic [NUM_SRC-1:0]       smp_vld,
    input  logic [SEL_W-1:0]         src_sel,
    output logic [SMP_W-1:0]         sel_smp,
    output logic                     sel_vld,
    output logic                     sel_chg
);
    logic [SMP_W-1:0] lane [NUM_SRC];
    logic [SEL_W-1:0] sel_q;

    // Unpack the bus into one lane per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
        assign lane[g] = smp_bus[g*SMP_W +: SMP_W];
    end

    // Route the selected lane and its strobe.
    always_comb begin
        sel_smp = lane[src_sel];
        sel_vld = smp_vld[src_sel];
    end

    // Remember last cycle's select to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= src_sel;
    end

    assign sel_chg = rst_n && (src_sel != sel_q);
endmodule

// File: rtl/mon_level_track.sv
// Tracks, for the selected source, the latest sample and the largest
// saturated magnitude since the last clear. A clear that coincides with
// a valid sample reloads the peak with that sample's magnitude.
// Assumes: samples are two's complement, SMP_W >= 2.
module mon_level_track #(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp,
    input  logic             vld,
    input  logic             clr,
    output logic [SMP_W-1:0] sample_q,
    output logic [SMP_W-1:0] peak_q
);
    localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] MOST_POS = ~MOST_NEG;
    localparam logic [SMP_W-1:0] ONE      = {{(SMP_W-1){1'b0}}, 1'b1};

    logic [SMP_W-1:0] mag;

    // Absolute value with the one overflow case saturated.
    always_comb begin
        if (!smp[SMP_W-1])       mag = smp;
        else if (smp == MOST_NEG) mag = MOST_POS;
        else                      mag = (~smp) + ONE;
    end

    // Latest-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n)   sample_q <= '0;
        else if (vld) sample_q <= smp;
    end

    // Peak register: clear (with seeding) takes priority over growth.
    always_ff @(posedge clk) begin
        if (!rst_n)                  peak_q <= '0;
        else if (clr)                peak_q <= vld ? mag : '0;
        else if (vld && mag > peak_q) peak_q <= mag;
    end

    // A clear without a sample leaves zero behind.
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !vld) |=> (peak_q == '0));

    // Without a clear the peak never shrinks.
    p_peak_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (peak_q >= $past(peak_q)));

    // The peak never shows a set sign bit.
    p_mag_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        peak_q[SMP_W-1] == 1'b0);

    // An unqualified cycle leaves the sample alone.
    p_sample_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(sample_q));
endmodule

// File: rtl/mon_read_port.sv
// Two-strobe byte read port. The high strobe freezes the mode-selected
// value and returns its upper byte. The low strobe returns the lower
// byte of the frozen value and, in peak mode, requests a peak clear.
// Assumes: SMP_W is even; rd_hi wins when both strobes are high.
module mon_read_port
    import mon_pkg::*;
#(
    parameter int SMP_W  = 16,
    localparam int BYTE_W = SMP_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              peak_mode,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic [SMP_W-1:0]  sample_val,
    input  logic [SMP_W-1:0]  peak_val,
    output logic [BYTE_W-1:0] rd_data,
    output logic              clr_rd
);
    logic [SMP_W-1:0] cur_val;
    logic [SMP_W-1:0] hold_q;

    // Choose which tracked result a read sees.
    assign cur_val = (peak_mode == MON_PEAK) ? peak_val : sample_val;

    // Peak clear request on a lone low-byte read in peak mode.
    assign clr_rd = rd_lo && !rd_hi && (peak_mode == MON_PEAK);

    // Freeze the full value on the high-byte strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (rd_hi) hold_q <= cur_val;
    end

    // Drive the output byte for whichever strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_hi) rd_data <= cur_val[SMP_W-1 -: BYTE_W];
        else if (rd_lo) rd_data <= hold_q[BYTE_W-1:0];
    end

    p_hi_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (rd_data == $past(cur_val[SMP_W-1 -: BYTE_W])));

    p_lo_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !rd_hi) |=> (rd_data == $past(hold_q[BYTE_W-1:0])));

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi |=> $stable(hold_q));

    p_idle_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hi && !rd_lo) |=> $stable(rd_data));
endmodule

// File: rtl/sig_monitor.sv
// Signal monitor top: source selection, level tracking and the byte
// read port. Peak clears come from a peak-mode low-byte read or from a
// change of source select.
// Assumes: SMP_W = 16 for a two-byte readout; inputs are synchronous.
module sig_monitor #(
    parameter int NUM_SRC = 8,
    parameter int SMP_W   = 16,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int BYTE_W = SMP_W / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC*SMP_W-1:0] smp_bus,
    input  logic [NUM_SRC-1:0]       smp_vld,
    input  logic [SEL_W-1:0]         src_sel,
    input  logic                     peak_mode,
    input  logic                     rd_hi,
    input  logic                     rd_lo,
    output logic [BYTE_W-1:0]        rd_data
);
    logic [SMP_W-1:0] sel_smp;
    logic             sel_vld;
    logic             sel_chg;
    logic             clr_rd;
    logic             clr_pk;
    logic [SMP_W-1:0] sample_q;
    logic [SMP_W-1:0] peak_q;

    mon_src_mux #(.NUM_SRC(NUM_SRC), .SMP_W(SMP_W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_bus (smp_bus),
        .smp_vld (smp_vld),
        .src_sel (src_sel),
        .sel_smp (sel_smp),
        .sel_vld (sel_vld),
        .sel_chg (sel_chg)
    );

    // Either clear source restarts the peak window.
    assign clr_pk = clr_rd || sel_chg;

    mon_level_track #(.SMP_W(SMP_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (sel_smp),
        .vld      (sel_vld),
        .clr      (clr_pk),
        .sample_q (sample_q),
        .peak_q   (peak_q)
    );

    mon_read_port #(.SMP_W(SMP_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .peak_mode  (peak_mode),
        .rd_hi      (rd_hi),
        .rd_lo      (rd_lo),
        .sample_val (sample_q),
        .peak_val   (peak_q),
        .rd_data    (rd_data),
        .clr_rd     (clr_rd)
    );

    // A select change must reach the tracker as a clear.
    p_sel_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel != $past(src_sel)) |-> clr_pk);

    // A sample-mode read never clears the peak.
    p_sample_noclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!peak_mode && !sel_chg) |-> !clr_pk);
endmodule

// File: tb/sig_monitor_bench.sv
module sig_monitor_bench;
    localparam int NS = 8;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS*W-1:0] smp_bus = '0;
    logic [NS-1:0]   smp_vld = '0;
    logic [2:0]      src_sel = '0;
    logic            peak_mode = 1'b0;
    logic            rd_hi = 1'b0;
    logic            rd_lo = 1'b0;
    logic [7:0]      rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    sig_monitor u_sig_monitor (
        .clk(clk), .rst_n(rst_n), .smp_bus(smp_bus), .smp_vld(smp_vld),
        .src_sel(src_sel), .peak_mode(peak_mode), .rd_hi(rd_hi),
        .rd_lo(rd_lo), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    // Fields: sel[51:49], mode[48], first[47:32], second[31:16], expect[15:0]
    localparam int NV = 11;
    localparam logic [51:0] VECS [NV] = '{
        {3'd0, 1'b0, 16'h1234, 16'h00A5, 16'h00A5},  // R2
        {3'd1, 1'b1, 16'h0100, 16'hFE00, 16'h0200},  // R4
        {3'd2, 1'b0, 16'h0005, 16'h8001, 16'h8001},  // R2
        {3'd3, 1'b1, 16'h7FFF, 16'h0001, 16'h7FFF},  // R4
        {3'd4, 1'b1, 16'hFFFF, 16'h0000, 16'h0001},  // R4
        {3'd5, 1'b0, 16'h7FFF, 16'hFFFF, 16'hFFFF},  // R2
        {3'd6, 1'b1, 16'h0300, 16'h0400, 16'h0400},  // R4
        {3'd7, 1'b0, 16'h0001, 16'h4321, 16'h4321},  // R2
        {3'd0, 1'b1, 16'hC000, 16'h3000, 16'h4000},  // R4
        {3'd1, 1'b0, 16'h0000, 16'h8000, 16'h8000},  // R2
        {3'd2, 1'b1, 16'h8000, 16'h0010, 16'h7FFF}   // R5
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle strobe on a single source.
    task automatic push(int src, logic [15:0] v);
        smp_bus[src*W +: W] = v;
        smp_vld = NS'(1) << src;
        @(negedge clk);
        smp_vld = '0;
    endtask

    task automatic read_hi(output logic [7:0] b);
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        b = rd_data;
    endtask

    task automatic read_lo(output logic [7:0] b);
        rd_lo = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
        b = rd_data;
    endtask

    task automatic read_pair(output logic [15:0] v);
        logic [7:0] h;
        logic [7:0] l;
        read_hi(h);
        read_lo(l);
        v = {h, l};
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  h;
        logic [7:0]  l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state in both modes
        check("R1 rd_data", {8'h00, rd_data}, 16'h0000);
        read_pair(v);
        check("R1 sample", v, 16'h0000);
        peak_mode = 1'b1;
        read_pair(v);
        check("R1 peak", v, 16'h0000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            src_sel   = VECS[i][51:49];
            peak_mode = VECS[i][48];
            @(negedge clk);
            push(int'(VECS[i][51:49]), VECS[i][47:32]);
            push(int'(VECS[i][51:49]), VECS[i][31:16]);
            read_pair(v);
            check(VECS[i][48] ? "R4 table" : "R2 table", v, VECS[i][15:0]);
        end

        // R3: strobe on an unselected source leaks into neither result
        src_sel = 3'd3; peak_mode = 1'b0;
        @(negedge clk);
        push(3, 16'h1111);
        push(4, 16'h2222);
        read_pair(v);
        check("R3 sample", v, 16'h1111);
        peak_mode = 1'b1;
        push(4, 16'h7000);
        read_pair(v);
        check("R3 peak", v, 16'h1111);

        // R7: frozen pair; R8: peak cleared afterwards
        push(3, 16'h0123);
        read_hi(h);
        push(3, 16'h7000);
        read_lo(l);
        check("R7 pair", {h, l}, 16'h0123);
        read_pair(v);
        check("R8 cleared", v, 16'h0000);

        // R9: sample in the clearing cycle seeds the peak
        push(3, 16'h0500);
        read_hi(h);
        smp_bus[3*W +: W] = 16'hFFE0;
        smp_vld = 8'h08;
        rd_lo = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0; smp_vld = '0;
        l = rd_data;
        check("R9 old pair", {h, l}, 16'h0500);
        read_pair(v);
        check("R9 seeded", v, 16'h0020);

        // R8: sample-mode reads clear nothing
        peak_mode = 1'b0;
        push(3, 16'h0042);
        read_pair(v);
        check("R8 sample1", v, 16'h0042);
        read_pair(v);
        check("R8 sample2", v, 16'h0042);
        peak_mode = 1'b1;
        read_pair(v);
        check("R8 peak kept", v, 16'h0042);

        // R10: select change clears, and seeds when a sample coincides
        push(3, 16'h0600);
        src_sel = 3'd4;
        @(negedge clk);
        read_pair(v);
        check("R10 clear", v, 16'h0000);
        push(4, 16'h0600);
        src_sel = 3'd5;
        smp_bus[5*W +: W] = 16'h0011;
        smp_vld = 8'h20;
        @(negedge clk);
        smp_vld = '0;
        read_pair(v);
        check("R10 seeded", v, 16'h0011);

        // R6: both strobes act as high-byte only, no clear
        push(5, 16'h0ABC);
        rd_hi = 1'b1; rd_lo = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0; rd_lo = 1'b0;
        check("R6 both strobes", {8'h00, rd_data}, 16'h000A);
        @(negedge clk);
        check("R6 idle hold", {8'h00, rd_data}, 16'h000A);
        read_pair(v);
        check("R6 no clear", v, 16'h0ABC);

        // R11: mode at rd_hi picks the result
        src_sel = 3'd6; peak_mode = 1'b0;
        @(negedge clk);
        push(6, 16'hFFF0);
        read_pair(v);
        check("R11 sample", v, 16'hFFF0);
        peak_mode = 1'b1;
        read_pair(v);
        check("R11 peak", v, 16'h0010);

        // R5: most negative value alone
        push(6, 16'h8000);
        read_pair(v);
        check("R5 saturate", v, 16'h7FFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule